// File: doc/BRIEF.md
# Sprite DMA Slot Allocator

This block decides, for every colour clock of a scanline, whether the cycle belongs to sprite DMA. Each of eight sprite channels has two odd colour-clock slots of its own. Sprite n fetches its first word at clock 21 + 4n ($15 + 4n) and its second word two clocks later. A slot is granted only when the sprite channel is active and sprite DMA is enabled. The enable is read again in every slot, so a single sprite can get its first word and not its second, or the reverse.

The enable comes from a DMA-control write. The write is a strobe with a two-bit field: bit 0 is the sprite enable and bit 1 is the master DMA enable. A write reaches the slot logic a fixed number of clocks after its strobe cycle. A grant reports the sprite index and the word index. A busy flag tells lower-priority requesters whether they may take the cycle. A capture strobe marks the first word of a sprite's fetch.

Top module: `sprite_slot_alloc`

## Requirements
- R1: Sprite n (0..7) is granted only at hpos = 21 + 4n (first word) and hpos = 23 + 4n (second word). No grant occurs on an even clock, below 21 or above 51.
- R2: A slot is granted only when both committed enable bits are 1: ctl_wdata bit 0 (sprite enable) and bit 1 (master enable). With either bit 0, no slot is granted.
- R3: A slot of sprite n is not granted while spr_active[n] is 0. The slots of other sprites are not affected.
- R4: During a grant, grant_idx equals n and grant_word is 0 in the first slot and 1 in the second.
- R5: capture pulses only in a granted first-word slot. It stays low in second-word slots and in slots that are not granted.
- R6: slot_busy is high exactly in granted cycles and low otherwise, so another requester may use the cycle.
- R7: A write whose strobe is high in the cycle with hpos = h first affects the slot decision at hpos = h + COMMIT_DLY (default 3). Slots before that use the previous enable.
- R8: The enable is sampled separately in each slot. A commit that lands between a sprite's two slots changes only the second slot.
- R9: Reset clears the committed enable and discards writes still in flight. No slot is granted after reset until a new write commits.
- R10: When no slot is granted, grant_idx and grant_word are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Colour-clock rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hpos | input | 9 | Horizontal colour-clock counter |
| ctl_wr | input | 1 | DMA-control write strobe |
| ctl_wdata | input | 2 | Bit 0: sprite DMA enable; bit 1: master DMA enable |
| spr_active | input | 8 | Per-sprite channel active flags |
| grant | output | 1 | Slot granted to sprite DMA this cycle |
| grant_idx | output | 3 | Sprite number of the granted slot |
| grant_word | output | 1 | 0 for the first word, 1 for the second |
| capture | output | 1 | Strobe at a sprite's granted first slot |
| slot_busy | output | 1 | Cycle is taken by sprite DMA |

## Verification
Some properties are checked by assertions on every cycle. A grant lands only on the odd clock of the granted sprite and word, and only while that sprite is active. capture only appears with a first-word grant. The busy flag stays low outside the sprite area. The index and word outputs stay zero when nothing is granted. The commit latency, the per-slot split between a sprite's two words, the two-bit enable, and the loss of in-flight writes at reset depend on the order of writes. Only the bench's directed scenarios show these, by placing writes at chosen clocks and observing the slots around the commit point.

// File: rtl/spr_slot_pkg.sv
package spr_slot_pkg;

  typedef enum logic {
    WORD_FIRST  = 1'b0,
    WORD_SECOND = 1'b1
  } spr_word_e;

  // Colour clock of sprite n, word w (0 first, 1 second).
  function automatic int slot_clock(input int base, input int spacing,
                                    input int gap, input int n, input int w);
    return base + spacing * n + gap * w;
  endfunction

endpackage

// File: rtl/spr_dma_commit.sv
// Delays the decoded sprite enable of a control write by COMMIT_DLY clocks.
module spr_dma_commit #(
  parameter int COMMIT_DLY = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [1:0] wdata,
  output logic       en_q
);

  logic wr_en_dec;
  logic arrive_v;
  logic arrive_d;
  logic en_d;

  assign wr_en_dec = wdata[0] & wdata[1];

  generate
    if (COMMIT_DLY <= 1) begin : g_direct
      assign arrive_v = wr;
      assign arrive_d = wr_en_dec;
    end else begin : g_pipe
      localparam int PIPE_N = COMMIT_DLY - 1;
      logic [PIPE_N-1:0] pv_q, pv_d;
      logic [PIPE_N-1:0] pd_q, pd_d;

      always_comb begin
        pv_d[0] = wr;
        pd_d[0] = wr_en_dec;
        for (int k = 1; k < PIPE_N; k++) begin
          pv_d[k] = pv_q[k-1];
          pd_d[k] = pd_q[k-1];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pv_q <= '0;
          pd_q <= '0;
        end else begin
          pv_q <= pv_d;
          pd_q <= pd_d;
        end
      end

      assign arrive_v = pv_q[PIPE_N-1];
      assign arrive_d = pd_q[PIPE_N-1];
    end
  endgenerate

  always_comb begin
    en_d = en_q;
    if (arrive_v) en_d = arrive_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

endmodule

// File: rtl/spr_slot_decode.sv
// Maps the horizontal position to a sprite slot, if any.
module spr_slot_decode
  import spr_slot_pkg::*;
#(
  parameter int NUM_SPR   = 8,
  parameter int HPOS_W    = 9,
  parameter int IDX_W     = 3,
  parameter int BASE_SLOT = 21,
  parameter int SPACING   = 4,
  parameter int PAIR_GAP  = 2
) (
  input  logic [HPOS_W-1:0] hpos,
  output logic              hit,
  output logic [IDX_W-1:0]  idx,
  output spr_word_e         word
);

  logic [NUM_SPR-1:0] hit_a;
  logic [NUM_SPR-1:0] hit_b;

  for (genvar n = 0; n < NUM_SPR; n++) begin : g_spr
    localparam logic [HPOS_W-1:0] SLOT_A =
      HPOS_W'(slot_clock(BASE_SLOT, SPACING, PAIR_GAP, n, 0));
    localparam logic [HPOS_W-1:0] SLOT_B =
      HPOS_W'(slot_clock(BASE_SLOT, SPACING, PAIR_GAP, n, 1));
    assign hit_a[n] = (hpos == SLOT_A);
    assign hit_b[n] = (hpos == SLOT_B);
  end

  always_comb begin
    hit  = 1'b0;
    idx  = '0;
    word = WORD_FIRST;
    for (int n = 0; n < NUM_SPR; n++) begin
      if (hit_a[n]) begin
        hit  = 1'b1;
        idx  = IDX_W'(n);
        word = WORD_FIRST;
      end
      if (hit_b[n]) begin
        hit  = 1'b1;
        idx  = IDX_W'(n);
        word = WORD_SECOND;
      end
    end
  end

endmodule

// File: rtl/sprite_slot_alloc.sv
module sprite_slot_alloc
  import spr_slot_pkg::*;
#(
  parameter int NUM_SPR    = 8,
  parameter int HPOS_W     = 9,
  parameter int BASE_SLOT  = 21,
  parameter int SPACING    = 4,
  parameter int PAIR_GAP   = 2,
  parameter int COMMIT_DLY = 3,
  localparam int IDX_W     = (NUM_SPR > 1) ? $clog2(NUM_SPR) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HPOS_W-1:0] hpos,
  input  logic              ctl_wr,
  input  logic [1:0]        ctl_wdata,
  input  logic [NUM_SPR-1:0] spr_active,
  output logic              grant,
  output logic [IDX_W-1:0]  grant_idx,
  output logic              grant_word,
  output logic              capture,
  output logic              slot_busy
);

  logic      en_q;
  logic      slot_hit;
  logic [IDX_W-1:0] slot_idx;
  spr_word_e slot_word;
  logic      grant_c;

  spr_dma_commit #(
    .COMMIT_DLY (COMMIT_DLY)
  ) u_commit (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (ctl_wr),
    .wdata (ctl_wdata),
    .en_q  (en_q)
  );

  spr_slot_decode #(
    .NUM_SPR   (NUM_SPR),
    .HPOS_W    (HPOS_W),
    .IDX_W     (IDX_W),
    .BASE_SLOT (BASE_SLOT),
    .SPACING   (SPACING),
    .PAIR_GAP  (PAIR_GAP)
  ) u_decode (
    .hpos (hpos),
    .hit  (slot_hit),
    .idx  (slot_idx),
    .word (slot_word)
  );

  always_comb begin
    grant_c    = slot_hit & en_q & spr_active[slot_idx];
    grant      = grant_c;
    grant_idx  = grant_c ? slot_idx : '0;
    grant_word = grant_c & (slot_word == WORD_SECOND);
    capture    = grant_c & (slot_word == WORD_FIRST);
    slot_busy  = grant_c;
  end

endmodule

// File: rtl/sprite_slot_alloc_chk.sv
module sprite_slot_alloc_chk #(
  parameter int NUM_SPR   = 8,
  parameter int HPOS_W    = 9,
  parameter int IDX_W     = 3,
  parameter int BASE_SLOT = 21,
  parameter int SPACING   = 4,
  parameter int PAIR_GAP  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [HPOS_W-1:0] hpos,
  input logic [NUM_SPR-1:0] spr_active,
  input logic              grant,
  input logic [IDX_W-1:0]  grant_idx,
  input logic              grant_word,
  input logic              capture,
  input logic              slot_busy
);

  localparam int LAST_SLOT = BASE_SLOT + SPACING * (NUM_SPR - 1) + PAIR_GAP;

  int off;
  int want_off;
  always_comb begin
    off      = int'(hpos) - BASE_SLOT;
    want_off = SPACING * int'(grant_idx) + PAIR_GAP * int'(grant_word);
  end

  AST_GRANT_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> hpos[0]); // R1
  AST_GRANT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (int'(hpos) >= BASE_SLOT && int'(hpos) <= LAST_SLOT)); // R1
  AST_GRANT_POSITION: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (off == want_off)); // R4
  AST_GRANT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> spr_active[grant_idx]); // R3
  AST_CAPTURE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> (grant && !grant_word)); // R5
  AST_BUSY_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(hpos) < BASE_SLOT || int'(hpos) > LAST_SLOT) |-> !slot_busy); // R6
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !grant |-> (grant_idx == '0 && !grant_word && !capture)); // R10

endmodule

bind sprite_slot_alloc sprite_slot_alloc_chk #(
  .NUM_SPR   (NUM_SPR),
  .HPOS_W    (HPOS_W),
  .IDX_W     (IDX_W),
  .BASE_SLOT (BASE_SLOT),
  .SPACING   (SPACING),
  .PAIR_GAP  (PAIR_GAP)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hpos       (hpos),
  .spr_active (spr_active),
  .grant      (grant),
  .grant_idx  (grant_idx),
  .grant_word (grant_word),
  .capture    (capture),
  .slot_busy  (slot_busy)
);

// File: tb/sprite_slot_alloc_bench.sv
module sprite_slot_alloc_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [8:0] hpos;
  logic       ctl_wr;
  logic [1:0] ctl_wdata;
  logic [7:0] spr_active;
  logic       grant;
  logic [2:0] grant_idx;
  logic       grant_word;
  logic       capture;
  logic       slot_busy;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  sprite_slot_alloc u_sprite_slot_alloc (
    .clk        (clk),
    .rst_n      (rst_n),
    .hpos       (hpos),
    .ctl_wr     (ctl_wr),
    .ctl_wdata  (ctl_wdata),
    .spr_active (spr_active),
    .grant      (grant),
    .grant_idx  (grant_idx),
    .grant_word (grant_word),
    .capture    (capture),
    .slot_busy  (slot_busy)
  );

  task automatic go(input int h);
    @(negedge clk);
    hpos   = 9'(h);
    ctl_wr = 1'b0;
    #1;
  endtask

  task automatic write_at(input int h, input bit spr, input bit mas);
    @(negedge clk);
    hpos      = 9'(h);
    ctl_wr    = 1'b1;
    ctl_wdata = {mas, spr};
    #1;
  endtask

  // Packed {grant, idx[2:0], word, capture, busy}
  task automatic expect_at(input string req, input int h, input bit en);
    int  exp_v;
    int  act_v;
    bit  hit;
    int  n;
    int  w;
    bit  g;
    hit = (h >= 21) && (h <= 51) && (((h - 21) % 2) == 0);
    n   = hit ? (h - 21) / 4 : 0;
    w   = (hit && ((h - 21) % 4) == 2) ? 1 : 0;
    g   = hit && en && spr_active[n];
    exp_v = g ? ((1 << 6) | (n << 3) | (w << 2) | ((w == 0 ? 1 : 0) << 1) | 1) : 0;
    act_v = (int'(grant) << 6) | (int'(grant_idx) << 3) | (int'(grant_word) << 2)
          | (int'(capture) << 1) | int'(slot_busy);
    checks++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s hpos=%0d actual=%b expected=%b", req, h, 7'(act_v), 7'(exp_v));
    end
  endtask

  task automatic sweep(input string req, input bit en);
    for (int h = 0; h < 64; h++) begin
      go(h);
      expect_at(req, h, en);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    go(21);
    expect_at("R9 in reset", 21, 1'b0);
    go(23);
    rst_n = 1'b1;
    sweep("R9 after reset", 1'b0);
  endtask

  task automatic t_full_line;
    write_at(0, 1'b1, 1'b1);
    go(1);
    go(2);
    sweep("R1 R4 R5 R6 R10", 1'b1);
  endtask

  task automatic t_master_bits;
    write_at(0, 1'b1, 1'b0);
    go(1);
    go(2);
    sweep("R2 master off", 1'b0);
    write_at(0, 1'b0, 1'b1);
    go(1);
    go(2);
    sweep("R2 sprite off", 1'b0);
  endtask

  task automatic t_active_mask;
    write_at(0, 1'b1, 1'b1);
    go(1);
    go(2);
    spr_active = 8'hA5;
    sweep("R3 mask A5", 1'b1);
    spr_active = 8'h5A;
    sweep("R3 mask 5A", 1'b1);
    spr_active = 8'hFF;
  endtask

  task automatic t_commit_delay;
    write_at(0, 1'b0, 1'b0);
    go(1);
    go(2);
    write_at(22, 1'b1, 1'b1);
    go(23);
    expect_at("R7 old value before commit", 23, 1'b0);
    go(24);
    go(25);
    expect_at("R7 new value at commit", 25, 1'b1);
    write_at(26, 1'b0, 1'b0);
    go(27);
    expect_at("R7 old enable held", 27, 1'b1);
    go(28);
    go(29);
    expect_at("R7 disable at commit", 29, 1'b0);
  endtask

  task automatic t_split_words;
    write_at(32, 1'b1, 1'b1);
    go(33);
    expect_at("R8 first word off", 33, 1'b0);
    go(34);
    go(35);
    expect_at("R8 second word on", 35, 1'b1);
    write_at(36, 1'b0, 1'b0);
    go(37);
    expect_at("R8 first word on", 37, 1'b1);
    go(38);
    go(39);
    expect_at("R8 second word off", 39, 1'b0);
  endtask

  task automatic t_reset_pending;
    write_at(40, 1'b1, 1'b1);
    go(41);
    rst_n = 1'b0;
    go(43);
    go(45);
    rst_n = 1'b1;
    sweep("R9 pending write dropped", 1'b0);
  endtask

  initial begin
    rst_n      = 1'b0;
    hpos       = '0;
    ctl_wr     = 1'b0;
    ctl_wdata  = '0;
    spr_active = 8'hFF;
    repeat (3) @(posedge clk);
    t_reset();
    t_full_line();
    t_master_bits();
    t_active_mask();
    t_commit_delay();
    t_split_words();
    t_reset_pending();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule